// File: doc/BRIEF.md
# PCI Configuration Address Phase Generator

This block sits on the host side of a PCI controller. It turns a configuration address word into the address phase of a PCI configuration cycle. The word holds an enable bit, a bus number, a device number, a function number and a register number. When software starts a cycle, the block looks at the bus number. A cycle for the controller's own bus uses the local format: the device number becomes a single IDSEL line on the AD bus. A cycle for any bus further away uses the forwarded format: the word is passed through nearly unchanged.

The block drives the command on C/BE. It also raises flags for three cases: a broadcast special cycle, an access to the controller's own configuration space, and a device number that has no IDSEL line. Every cycle uses address stepping. The address and command are put on the bus one clock before FRAME, so the target's IDSEL input can settle. FRAME is then held for one clock, and the block goes back to idle. The data phase and all handshaking are handled elsewhere.

Configuration word layout:

| Bits | Field |
|------|-------|
| 31 | Enable |
| 23:16 | Bus number |
| 15:11 | Device number |
| 10:8 | Function number |
| 7:2 | Register number |

Top module: `cfgphase_top`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `busy` is 0 and `frameAct` is 0. `adBus`, `cbeBus` and all four flags are also 0.
- R2: A cycle starts only when `startReq` is high, the block is idle, and the enable bit (bit 31 of `cfgWord`) is 1. A request that arrives while `busy` is 1, or with the enable bit clear, starts no cycle and changes nothing.
- R3: A start request is sampled on a clock edge. For the next clock, `busy` is 1 and `frameAct` is 0, with the final `adBus` and `cbeBus` values already driven. For the clock after that, `frameAct` is 1 and the values are unchanged. On the clock after that, the block is idle again.
- R4: When the bus field (bits 23:16) is not equal to `LOCAL_BUS`, `type1Flag` is 1. `adBus` then carries bits 31:2 of `cfgWord`, and `adBus[1:0]` is 2'b01.
- R5: When the bus field equals `LOCAL_BUS`, `adBus[10:2]` copies the function and register fields and `adBus[1:0]` is 2'b00. A device number from 11 to 30 sets only `adBus[device number]` among bits 31:11.
- R6: In the local format, device number 10 sets only `adBus[31]` among bits 31:11.
- R7: In the local format, device number 31 sets `specialFlag`. `cbeBus` is then 4'b0001 whatever `isWrite` is, and bits 31:11 of `adBus` are all 0.
- R8: In the local format, device number 0 sets `selfFlag`, and bits 31:11 of `adBus` are all 0.
- R9: In the local format, device numbers 1 to 9 set `abortFlag`, and bits 31:11 of `adBus` are all 0.
- R10: Except for a special cycle, `cbeBus` is 4'b1010 when `isWrite` is 0 and 4'b1011 when `isWrite` is 1.
- R11: In the forwarded format, `specialFlag`, `selfFlag` and `abortFlag` stay 0 for every device number, including 0 and 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 32 | Configuration address word |
| isWrite | input | 1 | 1 for a configuration write, 0 for a read |
| startReq | input | 1 | Start strobe, one clock |
| adBus | output | 32 | Address driven during the stepping and FRAME clocks |
| cbeBus | output | 4 | Command driven during the stepping and FRAME clocks |
| frameAct | output | 1 | FRAME, active high |
| busy | output | 1 | A cycle is in progress |
| type1Flag | output | 1 | Forwarded format in use |
| specialFlag | output | 1 | Special cycle |
| selfFlag | output | 1 | Access to the controller's own configuration space |
| abortFlag | output | 1 | Device number with no IDSEL line (ends as master abort) |

## Verification
Two things can happen in the same clock: a new start request and a cycle that is still in flight. The bench provokes this by raising `startReq` with a different word during the stepping clock, and again during the FRAME clock. The scoreboard expects exactly one address phase per accepted start. A second stepping phase would have no queued item and is judged a failure. The bench also checks that `adBus` and `cbeBus` stay unchanged through FRAME, and that the block is idle on the clock after FRAME.

// File: rtl/cfgphase_pkg.sv
package cfgphase_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_STEP, PH_FRAME} phase_t;

  typedef struct packed {
    logic capture;
    logic drive;
    logic frame;
  } ctrlStrobe_t;

  typedef struct packed {
    logic type1;
    logic special;
    logic self;
    logic abort;
  } decodeFlags_t;

  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
endpackage

// File: rtl/cfgphase_idsel.sv
module cfgphase_idsel #(
  parameter int AD_W       = 32,
  parameter int DEV_W      = 5,
  parameter int FIRST_LINE = 11,
  parameter int WRAP_DEV   = 10
) (
  input  logic [DEV_W-1:0] devNum,
  output logic [AD_W-1:0]  idselLines,
  output logic             isSpecial,
  output logic             isSelf,
  output logic             isAbort
);
  localparam logic [DEV_W-1:0] DEV_MAX = {DEV_W{1'b1}};

  for (genvar i = 0; i < AD_W; i++) begin : g_line
    if (i == AD_W - 1) begin : g_wrap
      assign idselLines[i] = (devNum == DEV_W'(WRAP_DEV));
    end else if (i >= FIRST_LINE) begin : g_direct
      assign idselLines[i] = (devNum == DEV_W'(i));
    end else begin : g_none
      assign idselLines[i] = 1'b0;
    end
  end

  assign isSpecial = (devNum == DEV_MAX);
  assign isSelf    = (devNum == '0);
  assign isAbort   = (devNum != '0) && (devNum < DEV_W'(WRAP_DEV));
endmodule

// File: rtl/cfgphase_ctrl.sv
module cfgphase_ctrl
  import cfgphase_pkg::*;
#(
  parameter int EN_BIT = 31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        enableBit,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (startReq && enableBit) phaseNext = PH_STEP;
      PH_STEP:  phaseNext = PH_FRAME;
      PH_FRAME: phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign strobe.capture = (phase == PH_IDLE) && startReq && enableBit;
  assign strobe.drive   = (phase != PH_IDLE);
  assign strobe.frame   = (phase == PH_FRAME);
  assign busy           = (phase != PH_IDLE);

  // R3: FRAME lasts a single clock
  p_frame_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frame |=> !strobe.frame);
  // R3: FRAME is preceded by a stepping clock
  p_step_before_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.frame) |-> $past(phase == PH_STEP));
  // R2: a request while busy starts nothing
  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && startReq) |=> phase != PH_STEP);
endmodule

// File: rtl/cfgphase_datapath.sv
module cfgphase_datapath
  import cfgphase_pkg::*;
#(
  parameter int AD_W       = 32,
  parameter int DEV_W      = 5,
  parameter int BUS_W      = 8,
  parameter int BUS_LSB    = 16,
  parameter int DEV_LSB    = 11,
  parameter int FIRST_LINE = 11,
  parameter int WRAP_DEV   = 10,
  parameter logic [BUS_W-1:0] LOCAL_BUS = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [AD_W-1:0] cfgWord,
  input  logic            isWrite,
  output logic [AD_W-1:0] adBus,
  output logic [3:0]      cbeBus,
  output decodeFlags_t    flags
);
  localparam int LOW_HI = DEV_LSB - 1;
  localparam logic [AD_W-1:0] LOW_MASK =
    ((AD_W'(1) << DEV_LSB) - AD_W'(1)) & ~AD_W'(3);

  logic [DEV_W-1:0] devNum;
  logic [AD_W-1:0]  idselLines;
  logic             isSpecial, isSelf, isAbort;
  logic             farBus;
  logic [AD_W-1:0]  adNext;
  logic [3:0]       cbeNext;
  decodeFlags_t     flagNext;
  logic [AD_W-1:0]  adReg;
  logic [3:0]       cbeReg;
  decodeFlags_t     flagReg;

  assign devNum = cfgWord[DEV_LSB +: DEV_W];
  assign farBus = (cfgWord[BUS_LSB +: BUS_W] != LOCAL_BUS);

  cfgphase_idsel #(
    .AD_W(AD_W), .DEV_W(DEV_W), .FIRST_LINE(FIRST_LINE), .WRAP_DEV(WRAP_DEV)
  ) idsel_i (
    .devNum(devNum), .idselLines(idselLines),
    .isSpecial(isSpecial), .isSelf(isSelf), .isAbort(isAbort)
  );

  always_comb begin
    flagNext = '0;
    if (farBus) begin
      adNext         = {cfgWord[AD_W-1:2], 2'b01};
      flagNext.type1 = 1'b1;
    end else begin
      adNext           = idselLines | (cfgWord & LOW_MASK);
      flagNext.special = isSpecial;
      flagNext.self    = isSelf;
      flagNext.abort   = isAbort;
    end
    if (flagNext.special)  cbeNext = CMD_SPECIAL;
    else if (isWrite)      cbeNext = CMD_CFG_WR;
    else                   cbeNext = CMD_CFG_RD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adReg   <= '0;
      cbeReg  <= '0;
      flagReg <= '0;
    end else if (strobe.capture) begin
      adReg   <= adNext;
      cbeReg  <= cbeNext;
      flagReg <= flagNext;
    end
  end

  assign adBus  = strobe.drive ? adReg   : '0;
  assign cbeBus = strobe.drive ? cbeReg  : '0;
  assign flags  = strobe.drive ? flagReg : '0;

  // R3: address and command are held through FRAME
  p_hold_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frame |-> ($stable(adBus) && $stable(cbeBus)));
  // R5: a normal local device drives exactly one IDSEL line
  p_idsel_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && !flags.type1 && !flags.special && !flags.self && !flags.abort)
      |-> $countones(adBus[AD_W-1:FIRST_LINE]) == 1);
  // R4: forwarded format marks its low bits
  p_type1_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && flags.type1) |-> adBus[1:0] == 2'b01);
  // R1: idle means nothing driven
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.drive |-> (adBus == '0 && cbeBus == '0 && flags == '0));
  // R11: forwarded format raises no local-decode flag
  p_far_noflags_r11: assert property (@(posedge clk) disable iff (!rstN)
    flags.type1 |-> !(flags.special || flags.self || flags.abort));
  // R9..R7: local-decode flags are mutually exclusive
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flags.special, flags.self, flags.abort}));
  localparam int UNUSED_LOW_HI = LOW_HI;
endmodule

// File: rtl/cfgphase_top.sv
module cfgphase_top
  import cfgphase_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int BUS_W = 8,
  parameter logic [7:0] LOCAL_BUS = 8'd0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AD_W-1:0] cfgWord,
  input  logic            isWrite,
  input  logic            startReq,
  output logic [AD_W-1:0] adBus,
  output logic [3:0]      cbeBus,
  output logic            frameAct,
  output logic            busy,
  output logic            type1Flag,
  output logic            specialFlag,
  output logic            selfFlag,
  output logic            abortFlag
);
  localparam int EN_BIT = AD_W - 1;

  ctrlStrobe_t  strobe;
  decodeFlags_t flags;

  cfgphase_ctrl #(.EN_BIT(EN_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .enableBit(cfgWord[EN_BIT]), .strobe(strobe), .busy(busy)
  );

  cfgphase_datapath #(
    .AD_W(AD_W), .BUS_W(BUS_W), .LOCAL_BUS(LOCAL_BUS[BUS_W-1:0])
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWord(cfgWord),
    .isWrite(isWrite), .adBus(adBus), .cbeBus(cbeBus), .flags(flags)
  );

  assign frameAct    = strobe.frame;
  assign type1Flag   = flags.type1;
  assign specialFlag = flags.special;
  assign selfFlag    = flags.self;
  assign abortFlag   = flags.abort;
endmodule

// File: tb/cfgphase_top_tb_top.sv
module cfgphase_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        isWrite = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] adBus;
  logic [3:0]  cbeBus;
  logic        frameAct, busy, type1Flag, specialFlag, selfFlag, abortFlag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic [3:0]  fl;  // type1, special, self, abort
    string       req;
  } exp_t;

  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgphase_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .isWrite(isWrite),
    .startReq(startReq), .adBus(adBus), .cbeBus(cbeBus), .frameAct(frameAct),
    .busy(busy), .type1Flag(type1Flag), .specialFlag(specialFlag),
    .selfFlag(selfFlag), .abortFlag(abortFlag)
  );

  function automatic exp_t model(logic [31:0] w, logic wr);
    exp_t e;
    int dev = int'(w[15:11]);
    e.fl = 4'b0000;
    if (w[23:16] != 8'd0) begin
      e.ad = {w[31:2], 2'b01};
      e.fl[3] = 1'b1;
      e.req = "R4/R11";
    end else begin
      e.ad = w & 32'h0000_07FC;
      if (dev >= 11 && dev <= 30) begin e.ad[dev] = 1'b1; e.req = "R5"; end
      else if (dev == 10) begin e.ad[31] = 1'b1; e.req = "R6"; end
      else if (dev == 31) begin e.fl[2] = 1'b1; e.req = "R7"; end
      else if (dev == 0) begin e.fl[1] = 1'b1; e.req = "R8"; end
      else begin e.fl[0] = 1'b1; e.req = "R9"; end
    end
    if (e.fl[2]) e.cbe = 4'b0001;
    else e.cbe = wr ? 4'b1011 : 4'b1010;  // R10
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: one start request, then wait out the cycle.
  // midStart: 1 = extra request in the stepping clock, 2 = in the FRAME clock
  task automatic runCycle(logic [31:0] w, logic wr, int midStart);
    @(negedge clk);
    cfgWord = w; isWrite = wr; startReq = 1'b1;
    expQ.push_back(model(w, wr));
    @(negedge clk);
    if (midStart == 1) begin cfgWord = w ^ 32'h0000_F800; isWrite = ~wr; end
    else startReq = 1'b0;
    @(negedge clk);
    if (midStart == 2) begin startReq = 1'b1; cfgWord = w ^ 32'h0001_0000; end
    else startReq = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Monitor: compares each address phase against the scoreboard
  int mphase = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rstN && !done) begin
      case (mphase)
        0: if (busy) begin
          if (expQ.size() == 0) begin
            check(0, "R2", "unexpected cycle", 64'(adBus), 64'(0));
          end else begin
            cur = expQ.pop_front();
            check(!frameAct, "R3", "frame during step", 64'(frameAct), 64'(0));
            check(adBus == cur.ad, cur.req, "adBus step", 64'(adBus), 64'(cur.ad));
            check(cbeBus == cur.cbe, "R10", "cbeBus", 64'(cbeBus), 64'(cur.cbe));
            check({type1Flag, specialFlag, selfFlag, abortFlag} == cur.fl, cur.req, "flags",
                  64'({type1Flag, specialFlag, selfFlag, abortFlag}), 64'(cur.fl));
          end
          mphase = 1;
        end
        1: begin
          check(frameAct && busy, "R3", "frame clock", 64'({busy, frameAct}), 64'(3));
          check(adBus == cur.ad && cbeBus == cur.cbe, "R3", "hold through frame",
                64'(adBus), 64'(cur.ad));
          mphase = 2;
        end
        default: begin
          check(!busy && !frameAct && adBus == 0 && cbeBus == 0, "R1", "idle after frame",
                64'({busy, frameAct, adBus}), 64'(0));
          mphase = 0;
        end
      endcase
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !frameAct && adBus == 0 && cbeBus == 0 &&
          {type1Flag, specialFlag, selfFlag, abortFlag} == 0,
          "R1", "reset state", 64'({busy, frameAct, adBus}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "idle after reset", 64'(busy), 64'(0));

    // R5 R6 R7 R8 R9: every device on the local bus, read and write
    for (int d = 0; d < 32; d++) begin
      runCycle({1'b1, 7'd0, 8'd0, 5'(d), 3'(d % 8), 6'(d * 3), 2'b00}, d[0], 0);
    end
    // R4 R11: every device on a remote bus
    for (int d = 0; d < 32; d++) begin
      runCycle({1'b1, 7'h2A, 8'(d + 1), 5'(d), 3'(7 - d % 8), 6'(63 - d), 2'b10}, ~d[0], 0);
    end
    // R10 R7: special cycle ignores the write flag
    runCycle({1'b1, 7'd0, 8'd0, 5'd31, 3'd0, 6'd0, 2'b00}, 1'b1, 0);
    runCycle({1'b1, 7'd0, 8'hFF, 5'd31, 3'd5, 6'd9, 2'b00}, 1'b1, 0);

    // R2: requests while busy start nothing
    runCycle({1'b1, 7'd0, 8'd0, 5'd17, 3'd2, 6'd4, 2'b00}, 1'b0, 1);
    runCycle({1'b1, 7'd0, 8'd3, 5'd12, 3'd1, 6'd8, 2'b00}, 1'b1, 2);
    repeat (3) @(negedge clk);
    check(!busy, "R2", "no cycle from busy request", 64'(busy), 64'(0));

    // R2: enable bit clear starts nothing
    @(negedge clk);
    cfgWord = {1'b0, 7'd0, 8'd0, 5'd20, 11'd0}; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(!busy && adBus == 0, "R2", "disabled request", 64'({busy, adBus}), 64'(0));
    repeat (2) @(negedge clk);
    check(!busy && expQ.size() == 0, "R2", "queue drained", 64'(expQ.size()), 64'(0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule